// File: doc/BRIEF.md
# Enhanced Parallel Port Address/Data Cycle Engine

This block runs the host side of enhanced parallel port address and data transfers. A host I/O read or write command arrives as an active-low strobe together with a register select (address or data) and an 8-bit system data bus. The block turns that command into a cycle on the port: it sets the direction of the port data bus, drives the active-low write line, and pulses either the data strobe or the address strobe.

The strobe is tied directly to the host command. It stays asserted until the host releases its read or write line. While the peripheral holds its active-low wait line low, the block pulls the host ready line low to stretch the host access. A programmable cycle counter bounds that stretch. When the counter expires, the block releases ready, drops the strobe and sets a sticky time-out flag.

A direction bit picks which command may start a cycle: 0 for writes, 1 for reads. A command that does not match the direction bit is ignored. The host loads the direction bit and clears the time-out flag through a one-cycle configuration write. The host command lines and the peripheral wait line are asynchronous and pass through two-flop synchronizers.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, both strobes and the write line are high, `pd_oe` is 0, `host_rdy` is 1, `tmo_flag` is 0 and `dir` is 0.
- R2: With `dir`=0, an active `host_wr_n` starts a write cycle. `pd_out` takes `host_wdata`, `pd_oe` becomes 1 and `p_write_n` becomes 0, all no later than the cycle in which the strobe first goes low.
- R3: `host_sel_addr`=1 selects the address strobe `p_astb_n` and `host_sel_addr`=0 selects the data strobe `p_dstb_n`. The two strobes are never low together.
- R4: With `dir`=1, an active `host_rd_n` starts a read cycle. `p_write_n` is 1 and `pd_oe` is 0 no later than the cycle in which the strobe first goes low.
- R5: `host_rdy` is low only while a strobe is low and the synchronized `p_wait_n` is low. `host_rdy` returns high after `p_wait_n` rises.
- R6: The strobe goes high after the host releases its command. After a write, `pd_out` keeps the written value until the next write cycle starts.
- R7: In a read cycle, `pd_in` is sampled while a strobe is low and `p_wait_n` is high. That value appears on `host_rdata` and is held there after the cycle ends.
- R8: If `p_wait_n` stays low for `TMO_CYCLES` strobe cycles, `host_rdy` is low for exactly `TMO_CYCLES` cycles. The strobe then goes high and `tmo_flag` is set.
- R9: `tmo_flag` is sticky. New cycles still run while it is set. A configuration write (`cfg_we`=1) with `cfg_tmo_clr`=1 clears it.
- R10: A command that does not match `dir` (a write while `dir`=1, or a read while `dir`=0) asserts no strobe and leaves `pd_out` and `pd_oe` unchanged.
- R11: A configuration write (`cfg_we`=1) loads `dir` from `cfg_dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_n | input | 1 | Host I/O read command, active low, asynchronous |
| host_wr_n | input | 1 | Host I/O write command, active low, asynchronous |
| host_sel_addr | input | 1 | Register select: 1 = address register, 0 = data register |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Data captured from the port during a read cycle |
| host_rdy | output | 1 | Host ready; low stretches the host access |
| cfg_we | input | 1 | One-cycle configuration write |
| cfg_dir | input | 1 | Direction value loaded on `cfg_we` |
| cfg_tmo_clr | input | 1 | When 1 during `cfg_we`, clears `tmo_flag` |
| dir | output | 1 | Current direction bit (0 = write, 1 = read) |
| tmo_flag | output | 1 | Sticky time-out flag |
| pd_out | output | DW | Port data driven toward the peripheral |
| pd_oe | output | 1 | Port data output enable |
| pd_in | input | DW | Port data from the peripheral |
| p_write_n | output | 1 | Write line to the peripheral, active low |
| p_dstb_n | output | 1 | Data strobe, active low |
| p_astb_n | output | 1 | Address strobe, active low |
| p_wait_n | input | 1 | Peripheral wait line, active low, asynchronous |

## Verification
The bench builds the block with `TMO_CYCLES`=20 and `DW`=8, so a full time-out fits into a few dozen cycles. It counts the exact number of cycles that ready stays low against that limit. The bench then runs a cycle with the sticky flag already set and clears the flag afterwards. Read and write cycles are run with both register selects, and with the wait line held low for part of a cycle, so the stretch of ready and the capture of read data after the wait line rises are both observed.

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine #(
  parameter int TMO_CYCLES = 2000,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_sel_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdy,
  input  logic          cfg_we,
  input  logic          cfg_dir,
  input  logic          cfg_tmo_clr,
  output logic          dir,
  output logic          tmo_flag,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic [DW-1:0] pd_in,
  output logic          p_write_n,
  output logic          p_dstb_n,
  output logic          p_astb_n,
  input  logic          p_wait_n
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_DONE} state_t;

  state_t        state;
  logic [1:0]    rd_q, wr_q, wait_q;
  logic [CW-1:0] cnt;
  logic          is_rd, sel_addr;

  wire rd_s   = rd_q[1];
  wire wr_s   = wr_q[1];
  wire wait_s = wait_q[1];
  wire cmd    = is_rd ? rd_s : wr_s;

  assign p_dstb_n = !(state == S_STRB && !sel_addr);
  assign p_astb_n = !(state == S_STRB && sel_addr);
  assign host_rdy = !(state == S_STRB && wait_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      wait_q <= '0;
    end else begin
      rd_q   <= {rd_q[0], ~host_rd_n};
      wr_q   <= {wr_q[0], ~host_wr_n};
      wait_q <= {wait_q[0], ~p_wait_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      is_rd      <= 1'b0;
      sel_addr   <= 1'b0;
      dir        <= 1'b0;
      tmo_flag   <= 1'b0;
      pd_out     <= '0;
      pd_oe      <= 1'b0;
      p_write_n  <= 1'b1;
      host_rdata <= '0;
    end else begin
      if (cfg_we) begin
        dir <= cfg_dir;
        if (cfg_tmo_clr) tmo_flag <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          if (wr_s && !dir) begin
            pd_out    <= host_wdata;
            pd_oe     <= 1'b1;
            p_write_n <= 1'b0;
            sel_addr  <= host_sel_addr;
            is_rd     <= 1'b0;
            state     <= S_SETUP;
          end else if (rd_s && dir) begin
            pd_oe     <= 1'b0;
            p_write_n <= 1'b1;
            sel_addr  <= host_sel_addr;
            is_rd     <= 1'b1;
            state     <= S_SETUP;
          end
        end
        S_SETUP: begin
          cnt   <= '0;
          state <= S_STRB;
        end
        S_STRB: begin
          if (!cmd) begin
            state <= S_IDLE;
          end else if (wait_s) begin
            if (cnt == CNT_LAST) begin
              tmo_flag <= 1'b1;
              state    <= S_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (is_rd) begin
            host_rdata <= pd_in;
          end
        end
        S_DONE: if (!cmd) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p_dstb_n,
  input logic          p_astb_n,
  input logic          p_write_n,
  input logic          pd_oe,
  input logic [DW-1:0] pd_out,
  input logic          host_rdy,
  input logic          tmo_flag,
  input logic          cfg_we,
  input logic          cfg_tmo_clr
);
  wire stb = !p_dstb_n || !p_astb_n;

  AST_ONE_STROBE:    assert property (@(posedge clk) disable iff (!rst_n) !(!p_dstb_n && !p_astb_n)); // R3
  AST_WRITE_DRIVES:  assert property (@(posedge clk) disable iff (!rst_n) (stb && !p_write_n) |-> pd_oe); // R2
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (stb && p_write_n) |-> !pd_oe); // R4
  AST_RDY_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !host_rdy |-> stb); // R5
  AST_DATA_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) (stb && $past(stb)) |-> $stable(pd_out)); // R6
  AST_TMO_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) (tmo_flag && !(cfg_we && cfg_tmo_clr)) |=> tmo_flag); // R9
endmodule

bind epp_cycle_engine epp_cycle_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .p_dstb_n(p_dstb_n), .p_astb_n(p_astb_n),
  .p_write_n(p_write_n), .pd_oe(pd_oe), .pd_out(pd_out), .host_rdy(host_rdy),
  .tmo_flag(tmo_flag), .cfg_we(cfg_we), .cfg_tmo_clr(cfg_tmo_clr)
);

// File: tb/epp_cycle_engine_bench.sv
`timescale 1ns/1ps
module epp_cycle_engine_bench;
  localparam int TMO = 20;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rd_n = 1'b1, host_wr_n = 1'b1, host_sel_addr = 1'b0;
  logic [DW-1:0] host_wdata = '0, pd_in = '0;
  logic cfg_we = 1'b0, cfg_dir = 1'b0, cfg_tmo_clr = 1'b0, p_wait_n = 1'b1;
  logic [DW-1:0] host_rdata, pd_out;
  logic host_rdy, dir, tmo_flag, pd_oe, p_write_n, p_dstb_n, p_astb_n;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  epp_cycle_engine #(.TMO_CYCLES(TMO), .DW(DW)) u_epp_cycle_engine (
    .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_sel_addr(host_sel_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdy(host_rdy), .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_tmo_clr(cfg_tmo_clr),
    .dir(dir), .tmo_flag(tmo_flag), .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
    .p_write_n(p_write_n), .p_dstb_n(p_dstb_n), .p_astb_n(p_astb_n), .p_wait_n(p_wait_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_write(input bit d, input bit clr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dir = d; cfg_tmo_clr = clr;
    @(negedge clk);
    cfg_we = 1'b0; cfg_tmo_clr = 1'b0;
  endtask

  task automatic wait_strobe(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!p_dstb_n || !p_astb_n) begin seen = 1'b1; break; end
    end
  endtask

  task automatic t_reset;
    check(p_dstb_n && p_astb_n && p_write_n, "R1 strobes/write high", {p_dstb_n, p_astb_n, p_write_n}, 7);
    check(!pd_oe && host_rdy, "R1 oe low rdy high", {pd_oe, host_rdy}, 1);
    check(!tmo_flag && !dir, "R1 flag/dir clear", {tmo_flag, dir}, 0);
  endtask

  task automatic t_write(input bit addr, input logic [DW-1:0] d);
    bit seen;
    host_sel_addr = addr; host_wdata = d; host_wr_n = 1'b0;
    wait_strobe(seen);
    check(seen, "R2 write strobe seen", seen, 1);
    check(pd_out == d && pd_oe && !p_write_n, "R2 data driven at strobe", pd_out, d);
    if (addr) check(!p_astb_n && p_dstb_n, "R3 address strobe", {p_astb_n, p_dstb_n}, 1);
    else      check(p_astb_n && !p_dstb_n, "R3 data strobe", {p_astb_n, p_dstb_n}, 2);
    tick(3);
    host_wr_n = 1'b1; host_wdata = ~d;
    tick(5);
    check(p_dstb_n && p_astb_n, "R6 strobe released", {p_dstb_n, p_astb_n}, 3);
    check(pd_out == d, "R6 write data held", pd_out, d);
  endtask

  task automatic t_read(input bit addr, input logic [DW-1:0] d);
    bit seen;
    int lows = 0;
    p_wait_n = 1'b0; pd_in = 8'h00;
    host_sel_addr = addr; host_rd_n = 1'b0;
    wait_strobe(seen);
    check(seen && p_write_n && !pd_oe, "R4 read setup at strobe", {seen, p_write_n, pd_oe}, 6);
    if (addr) check(!p_astb_n, "R3 read address strobe", p_astb_n, 0);
    else      check(!p_dstb_n, "R3 read data strobe", p_dstb_n, 0);
    tick(4);
    check(!host_rdy, "R5 rdy low while waiting", host_rdy, 0);
    pd_in = d; p_wait_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!host_rdy) lows++;
    end
    check(host_rdy && lows <= 3, "R5 rdy released after wait", lows, 2);
    host_rd_n = 1'b1;
    tick(5);
    pd_in = ~d;
    tick(2);
    check(p_dstb_n && p_astb_n, "R6 read strobe released", {p_dstb_n, p_astb_n}, 3);
    check(host_rdata == d, "R7 read data captured", host_rdata, d);
  endtask

  task automatic t_mismatch;
    bit seen;
    logic [DW-1:0] old = pd_out;
    bit old_oe = pd_oe;
    host_wdata = 8'hE7; host_wr_n = 1'b0;
    wait_strobe(seen);
    check(!seen, "R10 write ignored while dir=1", seen, 0);
    check(pd_out == old && pd_oe == old_oe, "R10 port unchanged", pd_out, old);
    host_wr_n = 1'b1;
    tick(4);
  endtask

  task automatic t_timeout;
    bit seen;
    int lows = 0;
    p_wait_n = 1'b0; host_sel_addr = 1'b0; host_wdata = 8'h3C; host_wr_n = 1'b0;
    wait_strobe(seen);
    if (!host_rdy) lows++;
    for (int i = 0; i < TMO + 10; i++) begin
      @(negedge clk);
      if (!host_rdy) lows++;
    end
    check(lows == TMO, "R8 rdy low cycles", lows, TMO);
    check(tmo_flag, "R8 flag set", tmo_flag, 1);
    check(p_dstb_n && p_astb_n, "R8 strobe dropped", {p_dstb_n, p_astb_n}, 3);
    host_wr_n = 1'b1; p_wait_n = 1'b1;
    tick(5);
  endtask

  task automatic t_sticky;
    bit seen;
    host_sel_addr = 1'b1; host_wdata = 8'h81; host_wr_n = 1'b0;
    wait_strobe(seen);
    check(seen && pd_out == 8'h81, "R9 cycle runs with flag set", pd_out, 8'h81);
    host_wr_n = 1'b1;
    tick(5);
    check(tmo_flag, "R9 flag still set", tmo_flag, 1);
    cfg_write(1'b0, 1'b0);
    tick(1);
    check(tmo_flag, "R9 write without clear keeps flag", tmo_flag, 1);
    cfg_write(1'b0, 1'b1);
    tick(1);
    check(!tmo_flag, "R9 flag cleared", tmo_flag, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    t_reset;
    rst_n = 1'b1;
    tick(3);
    t_write(1'b0, 8'hA5);
    t_write(1'b1, 8'h5A);
    cfg_write(1'b1, 1'b0);
    tick(1);
    check(dir, "R11 dir loaded", dir, 1);
    t_read(1'b0, 8'hC3);
    t_read(1'b1, 8'h1E);
    t_mismatch;
    cfg_write(1'b0, 1'b0);
    tick(1);
    check(!dir, "R11 dir cleared", dir, 0);
    t_timeout;
    t_sticky;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule